// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches eight already-synchronized GPIO input levels. For each pin it raises a sticky pending bit when that pin's chosen trigger condition occurs. The trigger can be a rising edge, a falling edge, either edge, a high level or a low level. Software reads the pending byte at any time and may clear individual bits by writing ones. A per-pin enable mask selects which pending bits contribute to a single combined interrupt request.

The trigger type is not stored as a packed field per pin. It is spread over three 8-bit planes of one 24-bit configuration word:

- Bits [7:0] hold the polarity.
- Bits [15:8] select edge (1) or level (0).
- Bits [23:16] request both edges.

Register decode, input synchronization and routing of the request to an interrupt controller are handled outside this block.

Edge detection compares each pin with its value from the previous clock. The first clock after reset only primes that history and never reports an edge. Pending bits are registered, so a trigger seen at a clock edge becomes visible on `pend_stat` just after that edge. The request output follows the pending bits and the enable mask without further delay.

Top module: `gpio_irq_det`

## Requirements
- R1: While reset is asserted and just after it, `pend_stat` is 8'h00 and `irq_out` is 0.
- R2: Plane bits {both,edge,pol} = 011 for pin n set pending bit n at the clock where `pin_lvl[n]` is 1 and was 0 at the previous clock.
- R3: Plane bits 010 set pending bit n on a 1-to-0 change of `pin_lvl[n]` and not on a 0-to-1 change.
- R4: Plane bits 110 or 111 set pending bit n on any change of `pin_lvl[n]`.
- R5: Plane bits 001 (active-high level) set pending bit n at every clock where `pin_lvl[n]` is 1. A clear while the level persists is overridden at that same clock.
- R6: Plane bits 000, and also 100 (both-edges bit ignored when the edge bit is 0), act as active-low level: pending bit n is set at every clock where `pin_lvl[n]` is 0. The all-zero reset configuration therefore means active-low level.
- R7: A 1 in `clr_w1c[n]` clears pending bit n at the clock edge. A 0 leaves it unchanged. Without a clear, a pending bit never drops, so reading status has no side effect.
- R8: When a trigger for pin n and a clear of pin n fall on the same clock, the pending bit stays set.
- R9: Pending bits latch whatever the enable mask is. `irq_out` is the OR over all pins of pending AND `irq_en`, so it stays 0 while `irq_en` is 8'h00, which is the off state software must leave until it enables a pin.
- R10: At the first clock after reset is released, no edge trigger fires, whatever the pin levels are.
- R11: Each pin follows its own plane bits, so different pins may use different trigger types at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 8 | Synchronized pin levels |
| trig_cfg | input | 24 | Trigger planes: [7:0] polarity, [15:8] edge select, [23:16] both edges |
| irq_en | input | 8 | Per-pin interrupt enable |
| clr_w1c | input | 8 | Write-one-to-clear pulse per pin |
| pend_stat | output | 8 | Pending status per pin |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The checker watches several properties at every clock:

- Pending bits never drop unless a clear was written.
- The request stays low while the enable mask is empty.
- Active level conditions always show up as pending at the next clock.
- A clear under a pure-edge configuration with steady pins empties the cleared bits.
- Reset leaves the status at zero.

Some behaviour can only be shown by the bench's stimulus sequences:

- The exact edge semantics of each trigger type.
- Ignoring the both-edges bit in level mode.
- A trigger winning over a clear in the same clock.
- The quiet first clock after reset.
- Mixed per-pin configurations.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [2:0] {
        TRIG_LVL_LO = 3'd0,
        TRIG_LVL_HI = 3'd1,
        TRIG_FALL   = 3'd2,
        TRIG_RISE   = 3'd3,
        TRIG_ANY    = 3'd4
    } trig_kind_e;

    // Edge select off: level mode, polarity picks high or low, both-edges ignored.
    function automatic trig_kind_e decode_trig(input logic pol, input logic edg, input logic both);
        trig_kind_e k;
        if (!edg)      k = pol ? TRIG_LVL_HI : TRIG_LVL_LO;
        else if (both) k = TRIG_ANY;
        else           k = pol ? TRIG_RISE : TRIG_FALL;
        return k;
    endfunction

endpackage

// File: rtl/gpio_irq_trig_decode.sv
module gpio_irq_trig_decode
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic [3*N_PINS-1:0]     trig_cfg,
    output trig_kind_e [N_PINS-1:0] kind
);
    localparam int EDGE_BASE = N_PINS;
    localparam int BOTH_BASE = 2 * N_PINS;

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        assign kind[g] = decode_trig(trig_cfg[g], trig_cfg[EDGE_BASE+g], trig_cfg[BOTH_BASE+g]);
    end
endmodule

// File: rtl/gpio_irq_event.sv
module gpio_irq_event
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_PINS-1:0]       pin_lvl,
    input  trig_kind_e [N_PINS-1:0] kind,
    output logic [N_PINS-1:0]       evt
);
    logic [N_PINS-1:0] prev_q;
    logic              primed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= pin_lvl;
            primed_q <= 1'b1;
        end
    end

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        logic rise_w, fall_w;
        assign rise_w = primed_q & pin_lvl[g] & ~prev_q[g];
        assign fall_w = primed_q & ~pin_lvl[g] & prev_q[g];

        always_comb begin
            evt[g] = 1'b0;
            unique case (kind[g])
                TRIG_LVL_LO: evt[g] = ~pin_lvl[g];
                TRIG_LVL_HI: evt[g] = pin_lvl[g];
                TRIG_FALL:   evt[g] = fall_w;
                TRIG_RISE:   evt[g] = rise_w;
                TRIG_ANY:    evt[g] = rise_w | fall_w;
                default:     evt[g] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] evt,
    input  logic [N_PINS-1:0] clr_w1c,
    input  logic [N_PINS-1:0] irq_en,
    output logic [N_PINS-1:0] pend_q,
    output logic              irq
);
    logic [N_PINS-1:0] pend_d;

    // A trigger in the same cycle as a clear keeps the bit set.
    always_comb pend_d = (pend_q & ~clr_w1c) | evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign irq = |(pend_q & irq_en);
endmodule

// File: rtl/gpio_irq_det.sv
module gpio_irq_det
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_PINS-1:0]     pin_lvl,
    input  logic [3*N_PINS-1:0]   trig_cfg,
    input  logic [N_PINS-1:0]     irq_en,
    input  logic [N_PINS-1:0]     clr_w1c,
    output logic [N_PINS-1:0]     pend_stat,
    output logic                  irq_out
);
    trig_kind_e [N_PINS-1:0] kind;
    logic [N_PINS-1:0]       evt;

    gpio_irq_trig_decode #(.N_PINS(N_PINS)) u_dec (
        .trig_cfg (trig_cfg),
        .kind     (kind)
    );

    gpio_irq_event #(.N_PINS(N_PINS)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_lvl (pin_lvl),
        .kind    (kind),
        .evt     (evt)
    );

    gpio_irq_status #(.N_PINS(N_PINS)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .clr_w1c (clr_w1c),
        .irq_en  (irq_en),
        .pend_q  (pend_stat),
        .irq     (irq_out)
    );
endmodule

// File: rtl/gpio_irq_det_chk.sv
module gpio_irq_det_chk #(
    parameter int N_PINS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_PINS-1:0]   pin_lvl,
    input logic [3*N_PINS-1:0] trig_cfg,
    input logic [N_PINS-1:0]   irq_en,
    input logic [N_PINS-1:0]   clr_w1c,
    input logic [N_PINS-1:0]   pend_stat,
    input logic                irq_out
);
    logic [N_PINS-1:0] lvl_active;
    assign lvl_active = ~trig_cfg[2*N_PINS-1:N_PINS] & ~(trig_cfg[N_PINS-1:0] ^ pin_lvl);

    // R1
    reset_zero_chk: assert property (@(posedge clk) !rst_n |=> pend_stat == '0);

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_w1c) == '0) |-> ((pend_stat & $past(pend_stat)) == $past(pend_stat)));

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_w1c != '0) && (trig_cfg[2*N_PINS-1:N_PINS] == '1) && (pin_lvl == $past(pin_lvl)))
        |=> ((pend_stat & $past(clr_w1c)) == '0));

    // R5
    level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_active != '0) |=> ((pend_stat & $past(lvl_active)) == $past(lvl_active)));

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq_out);
endmodule

bind gpio_irq_det gpio_irq_det_chk #(.N_PINS(N_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_lvl   (pin_lvl),
    .trig_cfg  (trig_cfg),
    .irq_en    (irq_en),
    .clr_w1c   (clr_w1c),
    .pend_stat (pend_stat),
    .irq_out   (irq_out)
);

// File: tb/gpio_irq_det_bench.sv
module gpio_irq_det_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS      = 20;

    typedef struct packed {
        logic [7:0]  pin;
        logic [23:0] cfg;
        logic [7:0]  en;
        logic [7:0]  clr;
        logic [7:0]  exp_stat;
        logic        exp_irq;
        logic [3:0]  req;
    } row_t;

    // cfg planes {both, edge, pol}: rise 00FFFF, fall 00FF00, any FFFF00, high 0000FF, low 000000
    localparam row_t TBL [NROWS] = '{
        '{8'hFF, 24'h00FFFF, 8'h00, 8'h00, 8'h00, 1'b0, 4'd10}, // R10 first clock: no edge
        '{8'hFF, 24'h00FFFF, 8'h00, 8'h00, 8'h00, 1'b0, 4'd2},  // R2 steady high
        '{8'h0F, 24'h00FFFF, 8'h00, 8'h00, 8'h00, 1'b0, 4'd2},  // R2 falling ignored
        '{8'hFF, 24'h00FFFF, 8'h00, 8'h00, 8'hF0, 1'b0, 4'd2},  // R2 rise on F0, R9 latched masked
        '{8'hFF, 24'h00FFFF, 8'h10, 8'h00, 8'hF0, 1'b1, 4'd9},  // R9 enable -> irq, R7 read keeps
        '{8'hFF, 24'h00FFFF, 8'h10, 8'hF0, 8'h00, 1'b0, 4'd7},  // R7 clear
        '{8'h3C, 24'h00FF00, 8'h00, 8'h00, 8'hC3, 1'b0, 4'd3},  // R3 falling
        '{8'h3C, 24'h00FF00, 8'h00, 8'hFF, 8'h00, 1'b0, 4'd7},  // R7 clear all
        '{8'h5A, 24'hFFFF00, 8'h00, 8'h00, 8'h66, 1'b0, 4'd4},  // R4 both edges
        '{8'h5B, 24'hFFFF00, 8'h00, 8'h67, 8'h01, 1'b0, 4'd8},  // R8 event beats clear
        '{8'h5B, 24'hFFFF00, 8'hFF, 8'h00, 8'h01, 1'b1, 4'd7},  // R7 zero writes no effect
        '{8'h81, 24'h0000FF, 8'hFF, 8'h01, 8'h81, 1'b1, 4'd5},  // R5 high level
        '{8'h81, 24'h0000FF, 8'hFF, 8'h81, 8'h81, 1'b1, 4'd5},  // R5 re-set while active
        '{8'h00, 24'h0000FF, 8'hFF, 8'h81, 8'h00, 1'b0, 4'd5},  // R5 level gone
        '{8'hF0, 24'h000000, 8'h00, 8'h00, 8'h0F, 1'b0, 4'd6},  // R6 low level
        '{8'hFF, 24'hFF0000, 8'h00, 8'hFF, 8'h00, 1'b0, 4'd6},  // R6 100 as low level
        '{8'h0F, 24'hFF0000, 8'h00, 8'h00, 8'hF0, 1'b0, 4'd6},  // R6 low level sets
        '{8'h0F, 24'hFF0000, 8'h00, 8'hF0, 8'hF0, 1'b0, 4'd6},  // R6 re-set, not an edge
        '{8'hF0, 24'h040709, 8'h02, 8'hFF, 8'h06, 1'b1, 4'd11}, // R11 mixed: fall p1, any p2
        '{8'hF9, 24'h040709, 8'h02, 8'h06, 8'h09, 1'b0, 4'd11}  // R11 rise p0, high p3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_lvl = 8'hFF;
    logic [23:0] trig_cfg = '0;
    logic [7:0]  irq_en = '0;
    logic [7:0]  clr_w1c = '0;
    logic [7:0]  pend_stat;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_det u_gpio_irq_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_lvl   (pin_lvl),
        .trig_cfg  (trig_cfg),
        .irq_en    (irq_en),
        .clr_w1c   (clr_w1c),
        .pend_stat (pend_stat),
        .irq_out   (irq_out)
    );

    task automatic check(input int req, input string what, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s: got %02h expected %02h", req, what, got, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(1, "stat in reset", pend_stat, 8'h00);   // R1
        check(1, "irq in reset", {7'd0, irq_out}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NROWS; i++) begin
            pin_lvl  = TBL[i].pin;
            trig_cfg = TBL[i].cfg;
            irq_en   = TBL[i].en;
            clr_w1c  = TBL[i].clr;
            @(posedge clk);
            #1;
            check(int'(TBL[i].req), $sformatf("row %0d stat", i), pend_stat, TBL[i].exp_stat);
            check(int'(TBL[i].req), $sformatf("row %0d irq", i), {7'd0, irq_out}, {7'd0, TBL[i].exp_irq});
            @(negedge clk);
        end
        // R1 reset mid-run with status set and all enabled
        irq_en  = 8'hFF;
        clr_w1c = 8'h00;
        rst_n   = 1'b0;
        @(posedge clk);
        #1;
        check(1, "stat after reset", pend_stat, 8'h00);
        check(1, "irq after reset", {7'd0, irq_out}, 8'h00);
        // R6 zero config after reset is active-low level: pin low sets status
        @(negedge clk);
        trig_cfg = '0;
        pin_lvl  = 8'h01;
        irq_en   = 8'h00;
        rst_n    = 1'b1;
        @(posedge clk);
        #1;
        check(6, "default active-low", pend_stat, 8'hFE);
        check(9, "irq off by default", {7'd0, irq_out}, 8'h00);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule